// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This block tracks the interrupt sources of a 16550-style serial port and reports them to software. Each source has a pending flag. A source event sets its flag, and a defined register access clears it. From the enabled flags the block forms a 4-bit identification code that names the most urgent source. A fifth bit carries an autobaud-lock indication, which sits outside the priority order. The block also drives one interrupt line.

The surrounding UART supplies everything else as single-cycle strobes or levels: the receiver and transmitter FIFOs, the serial engine, the baud generator and the autobaud detector. The interrupt-enable bits come in the same way. When FIFO mode is selected, the receive-data source follows the trigger level. The transmit request in that mode fires when the transmit FIFO drains to half full or less, rather than waiting for it to empty. A character-timeout source exists only in FIFO mode.

Top module: `uart_irq_prio`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `iir` reads 5'b00001 and `irq` is low. Bit 0 of `iir` is 1 exactly when no prioritized source is reported.
- R2: A line-error strobe makes code 4'b0110 the reported code, ahead of every other source. Only a `rd_lsr` strobe clears it.
- R3: With FIFO mode off, `ev_rx_data` sets the receive-data source (code 4'b0100), and `rd_rbr` clears it.
- R4: With FIFO mode on, the receive-data source is cleared by `rx_below_trig` being high or by `fcr_rx_rst`. `rd_rbr` alone leaves it pending.
- R5: Character timeout (code 4'b1100) can be set only in FIFO mode. `rd_rbr`, `fcr_rx_rst` or leaving FIFO mode clears it. When receive data and timeout are both pending, code 4'b0100 is reported.
- R6: The transmit request (code 4'b0010) is set on the rising edge of its condition. With FIFO mode off the condition is `thr_empty`. With FIFO mode on it is `tx_count` <= TX_DEPTH/2. A `wr_thr` strobe clears the request.
- R7: A `rd_iir` strobe clears the transmit request only if `iir[3:0]` showed 4'b0010 in that same cycle.
- R8: Any change on the 4 bits of `modem_in` sets the modem source (code 4'b0000, the lowest priority). `rd_msr` clears it.
- R9: `ev_ab_lock` sets `iir[4]`, independent of the code in `iir[3:0]`. A `rd_iir` strobe while `iir[4]` is 1 clears it.
- R10: Enable bits in `ien`: bit 0 covers receive data and timeout, bit 1 the transmit request, bit 2 line errors, bit 3 modem and bit 4 autobaud lock. A disabled source is absent from `iir` and from `irq`, but its flag is kept. `irq` is high exactly when `iir[0]` is 0 or `iir[4]` is 1.
- R11: When a set and a clear arrive in the same cycle, the source stays pending.
- R12: A strobe sampled at one clock edge appears on `iir` and `irq` after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode selected |
| ien | input | 5 | Per-source interrupt enables |
| ev_line_err | input | 1 | Overrun/parity/framing/break strobe |
| ev_rx_data | input | 1 | Receive buffer full or trigger level reached |
| rx_below_trig | input | 1 | Receive FIFO level is below the trigger (level) |
| ev_timeout | input | 1 | Receive character timeout strobe |
| thr_empty | input | 1 | Holding register empty (level, FIFO mode off) |
| tx_count | input | CW | Transmit FIFO occupancy |
| modem_in | input | 4 | Modem control input lines |
| ev_ab_lock | input | 1 | Autobaud lock strobe |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_rbr | input | 1 | Receive buffer / FIFO read strobe |
| rd_iir | input | 1 | Identification register read strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| wr_thr | input | 1 | Holding register / transmit FIFO write strobe |
| fcr_rx_rst | input | 1 | Receive FIFO reset strobe |
| iir | output | 5 | {autobaud lock, 4-bit identification code} |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle. Line errors and modem changes are never dropped without their clearing read. The transmit request survives any cycle without a qualifying clear. Timeout cannot become pending outside FIFO mode. The interrupt line always agrees with the code and the lock bit.

Other behaviours show only through the bench's scenarios against its model: the exact code chosen under each mix of sources, the half-full edge in FIFO mode, an identification read racing a newly pending source, and enable gating of stale flags.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC  = 6;
  localparam int S_LINE = 0;
  localparam int S_RXD  = 1;
  localparam int S_TMO  = 2;
  localparam int S_TXR  = 3;
  localparam int S_MDM  = 4;
  localparam int S_ABL  = 5;

  localparam int NEN    = 5;
  localparam int EN_RX  = 0;
  localparam int EN_TX  = 1;
  localparam int EN_LN  = 2;
  localparam int EN_MD  = 3;
  localparam int EN_AB  = 4;

  localparam logic [3:0] ID_NONE = 4'b0001;
  localparam logic [3:0] ID_LINE = 4'b0110;
  localparam logic [3:0] ID_RXD  = 4'b0100;
  localparam logic [3:0] ID_TMO  = 4'b1100;
  localparam logic [3:0] ID_TXR  = 4'b0010;
  localparam logic [3:0] ID_MDM  = 4'b0000;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int W         = 1,
  parameter bit RISE_ONLY = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic         hit
);
  logic [W-1:0] prev;
  logic         primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= '0;
      primed <= 1'b0;
    end else begin
      prev   <= d;
      primed <= 1'b1;
    end
  end

  generate
    if (RISE_ONLY) begin : g_rise
      assign hit = primed & (|(d & ~prev));
    end else begin : g_any
      assign hit = primed & (|(d ^ prev));
    end
  endgenerate
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  // a set in the same cycle as a clear wins, so no event is lost
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= set | (pend & ~clr);
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] vis,
  output logic [3:0]      code
);
  always_comb begin
    if      (vis[S_LINE]) code = ID_LINE;
    else if (vis[S_RXD])  code = ID_RXD;
    else if (vis[S_TMO])  code = ID_TMO;
    else if (vis[S_TXR])  code = ID_TXR;
    else if (vis[S_MDM])  code = ID_MDM;
    else                  code = ID_NONE;
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int MDM_W    = 4,
  parameter int CW       = $clog2(TX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic [NEN-1:0]   ien,
  input  logic             ev_line_err,
  input  logic             ev_rx_data,
  input  logic             rx_below_trig,
  input  logic             ev_timeout,
  input  logic             thr_empty,
  input  logic [CW-1:0]    tx_count,
  input  logic [MDM_W-1:0] modem_in,
  input  logic             ev_ab_lock,
  input  logic             rd_lsr,
  input  logic             rd_rbr,
  input  logic             rd_iir,
  input  logic             rd_msr,
  input  logic             wr_thr,
  input  logic             fcr_rx_rst,
  output logic [4:0]       iir,
  output logic             irq
);
  localparam int HALF = TX_DEPTH / 2;

  logic            tx_cond, tx_rise, mdm_chg;
  logic [NSRC-1:0] set, clr, pend, en_map, vis;
  logic [3:0]      code;
  logic [4:0]      iir_q;
  logic            irq_q;

  assign tx_cond = fifo_en ? (tx_count <= CW'(HALF)) : thr_empty;

  irq_edge_det #(.W(1), .RISE_ONLY(1'b1)) i_tx_edge (
    .clk(clk), .rst(rst), .d(tx_cond), .hit(tx_rise));

  irq_edge_det #(.W(MDM_W), .RISE_ONLY(1'b0)) i_mdm_edge (
    .clk(clk), .rst(rst), .d(modem_in), .hit(mdm_chg));

  // clear conditions use the code latched on the output for this read
  always_comb begin
    set = '0;
    clr = '0;
    set[S_LINE] = ev_line_err;
    clr[S_LINE] = rd_lsr;
    set[S_RXD]  = ev_rx_data;
    clr[S_RXD]  = fifo_en ? (rx_below_trig | fcr_rx_rst) : rd_rbr;
    set[S_TMO]  = ev_timeout & fifo_en;
    clr[S_TMO]  = rd_rbr | fcr_rx_rst | ~fifo_en;
    set[S_TXR]  = tx_rise;
    clr[S_TXR]  = wr_thr | (rd_iir & (iir_q[3:0] == ID_TXR));
    set[S_MDM]  = mdm_chg;
    clr[S_MDM]  = rd_msr;
    set[S_ABL]  = ev_ab_lock;
    clr[S_ABL]  = rd_iir & iir_q[4];
  end

  irq_pend_bank #(.N(NSRC)) i_bank (
    .clk(clk), .rst(rst), .set(set), .clr(clr), .pend(pend));

  always_comb begin
    en_map         = '0;
    en_map[S_LINE] = ien[EN_LN];
    en_map[S_RXD]  = ien[EN_RX];
    en_map[S_TMO]  = ien[EN_RX];
    en_map[S_TXR]  = ien[EN_TX];
    en_map[S_MDM]  = ien[EN_MD];
    en_map[S_ABL]  = ien[EN_AB];
  end

  assign vis = pend & en_map;

  irq_prio_enc i_enc (.vis(vis), .code(code));

  always_ff @(posedge clk) begin
    if (rst) begin
      iir_q <= {1'b0, ID_NONE};
      irq_q <= 1'b0;
    end else begin
      iir_q <= {vis[S_ABL], code};
      irq_q <= |vis;
    end
  end

  assign iir = iir_q;
  assign irq = irq_q;
endmodule

// File: rtl/uart_irq_prio_chk.sv
module uart_irq_prio_chk
  import uart_irq_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] pend,
  input logic [4:0]      iir,
  input logic            irq,
  input logic [NEN-1:0]  ien,
  input logic            fifo_en,
  input logic            ev_line_err,
  input logic            rd_lsr,
  input logic            rd_msr,
  input logic            rd_iir,
  input logic            wr_thr
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (iir == 5'b00001 && !irq));

  a_r2_line_held: assert property (@(posedge clk) disable iff (rst)
    (pend[S_LINE] && !rd_lsr) |=> pend[S_LINE]);

  a_r2_line_top: assert property (@(posedge clk) disable iff (rst)
    (pend[S_LINE] && ien[EN_LN]) |=> (iir[3:0] == 4'b0110));

  a_r5_no_tmo_off: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && !pend[S_TMO]) |=> !pend[S_TMO]);

  a_r7_tx_kept: assert property (@(posedge clk) disable iff (rst)
    (pend[S_TXR] && !wr_thr && !(rd_iir && iir[3:0] == 4'b0010)) |=> pend[S_TXR]);

  a_r8_modem_held: assert property (@(posedge clk) disable iff (rst)
    (pend[S_MDM] && !rd_msr) |=> pend[S_MDM]);

  a_r10_irq_agrees: assert property (@(posedge clk) disable iff (rst)
    irq == (!iir[0] || iir[4]));

  a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
    ev_line_err |=> pend[S_LINE]);
endmodule

bind uart_irq_prio uart_irq_prio_chk i_chk (
  .clk(clk), .rst(rst), .pend(pend), .iir(iir), .irq(irq), .ien(ien),
  .fifo_en(fifo_en), .ev_line_err(ev_line_err), .rd_lsr(rd_lsr),
  .rd_msr(rd_msr), .rd_iir(rd_iir), .wr_thr(wr_thr));

// File: tb/test_uart_irq_prio.sv
module test_uart_irq_prio;
  localparam int CLK_PERIOD = 10;
  localparam int TXD = 16;
  localparam int CW  = $clog2(TXD + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic fifo_en, ev_line_err, ev_rx_data, rx_below_trig, ev_timeout, thr_empty;
  logic ev_ab_lock, rd_lsr, rd_rbr, rd_iir, rd_msr, wr_thr, fcr_rx_rst;
  logic [4:0] ien;
  logic [CW-1:0] tx_count;
  logic [3:0] modem_in;
  logic [4:0] iir;
  logic irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // model state: bits 0 line,1 rx,2 timeout,3 tx,4 modem,5 autobaud
  logic [5:0] m_pend;
  logic [4:0] m_iir;
  logic m_irq, m_tprev, m_primed;
  logic [3:0] m_mprev;

  uart_irq_prio #(.TX_DEPTH(TXD)) i_uart_irq_prio (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .ien(ien),
    .ev_line_err(ev_line_err), .ev_rx_data(ev_rx_data),
    .rx_below_trig(rx_below_trig), .ev_timeout(ev_timeout),
    .thr_empty(thr_empty), .tx_count(tx_count), .modem_in(modem_in),
    .ev_ab_lock(ev_ab_lock), .rd_lsr(rd_lsr), .rd_rbr(rd_rbr),
    .rd_iir(rd_iir), .rd_msr(rd_msr), .wr_thr(wr_thr),
    .fcr_rx_rst(fcr_rx_rst), .iir(iir), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] enc(input logic [5:0] v);
    if (v[0]) return 4'b0110;
    if (v[1]) return 4'b0100;
    if (v[2]) return 4'b1100;
    if (v[3]) return 4'b0010;
    if (v[4]) return 4'b0000;
    return 4'b0001;
  endfunction

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {irq,iir} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic strobes_off();
    ev_line_err = 0; ev_rx_data = 0; ev_timeout = 0; ev_ab_lock = 0;
    rd_lsr = 0; rd_rbr = 0; rd_iir = 0; rd_msr = 0; wr_thr = 0; fcr_rx_rst = 0;
  endtask

  task automatic step(input string tag);
    logic [5:0] en, vis, s, c, np;
    logic tcond;
    en = {ien[4], ien[3], ien[1], ien[0], ien[0], ien[2]};
    vis = m_pend & en;
    tcond = fifo_en ? (tx_count <= CW'(TXD/2)) : thr_empty;
    s = {ev_ab_lock, m_primed && (modem_in != m_mprev), m_primed && tcond && !m_tprev,
         ev_timeout && fifo_en, ev_rx_data, ev_line_err};
    c = {rd_iir && m_iir[4], rd_msr, wr_thr || (rd_iir && m_iir[3:0] == 4'b0010),
         rd_rbr || fcr_rx_rst || !fifo_en,
         fifo_en ? (rx_below_trig || fcr_rx_rst) : rd_rbr, rd_lsr};
    np = s | (m_pend & ~c);
    @(posedge clk);
    @(negedge clk);
    strobes_off();
    m_pend = np; m_iir = {vis[5], enc(vis)}; m_irq = |vis;
    m_mprev = modem_in; m_tprev = tcond; m_primed = 1'b1;
    check(tag, {irq, iir}, {m_irq, m_iir});
  endtask

  task automatic expect_now(input string tag, input logic [4:0] e_iir, input logic e_irq);
    check(tag, {irq, iir}, {e_irq, e_iir});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: run did not end");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    strobes_off();
    fifo_en = 0; ien = 5'b11111; rx_below_trig = 0; thr_empty = 0;
    tx_count = CW'(TXD); modem_in = 4'b0000;
    m_pend = 0; m_iir = 5'b00001; m_irq = 0; m_mprev = 0; m_tprev = 0; m_primed = 0;
    repeat (3) @(negedge clk);
    expect_now("R1 in reset", 5'b00001, 1'b0);
    rst = 0;
    @(negedge clk);
    expect_now("R1 after reset", 5'b00001, 1'b0);

    // R12 latency and R2 line status
    ev_line_err = 1; step("R12 strobe edge");
    expect_now("R12 one edge later still idle", 5'b00001, 1'b0);
    step("R2 set");
    expect_now("R2 line code", 5'b00110, 1'b1);
    rd_rbr = 1; rd_msr = 1; step("R2 wrong read"); step("R2 wrong read");
    expect_now("R2 held by other reads", 5'b00110, 1'b1);
    rd_lsr = 1; step("R2 clear"); step("R2 clear");
    expect_now("R2 cleared by lsr read", 5'b00001, 1'b0);

    // R3 non-FIFO receive data
    ev_rx_data = 1; step("R3 set"); step("R3 set");
    expect_now("R3 rx code", 5'b00100, 1'b1);
    rd_rbr = 1; step("R3 clear"); step("R3 clear");
    expect_now("R3 cleared", 5'b00001, 1'b0);

    // R4 FIFO receive data
    fifo_en = 1; step("R4 mode");
    ev_rx_data = 1; step("R4 set"); rd_rbr = 1; step("R4 rbr"); step("R4 rbr");
    expect_now("R4 rbr does not clear", 5'b00100, 1'b1);
    rx_below_trig = 1; step("R4 below"); rx_below_trig = 0; step("R4 below");
    expect_now("R4 below trigger clears", 5'b00001, 1'b0);
    ev_rx_data = 1; step("R4 set"); fcr_rx_rst = 1; step("R4 fcr"); step("R4 fcr");
    expect_now("R4 fifo reset clears", 5'b00001, 1'b0);

    // R5 timeout
    ev_timeout = 1; step("R5 set"); step("R5 set");
    expect_now("R5 timeout code", 5'b01100, 1'b1);
    ev_rx_data = 1; step("R5 both"); step("R5 both");
    expect_now("R5 rx data before timeout", 5'b00100, 1'b1);
    rx_below_trig = 1; step("R5 drop rx"); rx_below_trig = 0; step("R5 drop rx");
    expect_now("R5 timeout remains", 5'b01100, 1'b1);
    rd_rbr = 1; step("R5 clear"); step("R5 clear");
    expect_now("R5 cleared by read", 5'b00001, 1'b0);
    fifo_en = 0; step("R5 off"); ev_timeout = 1; step("R5 off"); step("R5 off");
    expect_now("R5 no timeout in non-FIFO", 5'b00001, 1'b0);

    // R6 transmit request
    thr_empty = 1; step("R6 empty"); step("R6 empty");
    expect_now("R6 tx code", 5'b00010, 1'b1);
    wr_thr = 1; step("R6 write"); step("R6 write");
    expect_now("R6 write clears, level no retrigger", 5'b00001, 1'b0);
    thr_empty = 0; fifo_en = 1; tx_count = CW'(9); step("R6 fifo"); step("R6 fifo");
    expect_now("R6 above half no request", 5'b00001, 1'b0);
    tx_count = CW'(8); step("R6 half"); step("R6 half");
    expect_now("R6 half full request", 5'b00010, 1'b1);

    // R7 read of identification register
    ev_line_err = 1; step("R7 line races");
    rd_iir = 1; step("R7 read latched tx");
    expect_now("R7 line shown", 5'b00110, 1'b1);
    rd_lsr = 1; step("R7 lsr"); step("R7 lsr");
    expect_now("R7 tx cleared by read", 5'b00001, 1'b0);
    tx_count = CW'(16); step("R7 refill"); tx_count = CW'(4); step("R7 drain");
    ev_line_err = 1; step("R7 both"); step("R7 both");
    rd_iir = 1; step("R7 read shows line"); rd_lsr = 1; step("R7 lsr"); step("R7 lsr");
    expect_now("R7 tx survives read of line code", 5'b00010, 1'b1);
    wr_thr = 1; step("R7 clean"); step("R7 clean");

    // R8 modem
    modem_in = 4'b0100; step("R8 change"); step("R8 change");
    expect_now("R8 modem code", 5'b00000, 1'b1);
    rd_msr = 1; step("R8 clear"); step("R8 clear");
    expect_now("R8 cleared", 5'b00001, 1'b0);

    // R9 autobaud
    ev_ab_lock = 1; step("R9 set"); step("R9 set");
    expect_now("R9 lock bit alone", 5'b10001, 1'b1);
    ev_line_err = 1; step("R9 with line"); step("R9 with line");
    expect_now("R9 lock beside code", 5'b10110, 1'b1);
    rd_iir = 1; step("R9 read"); step("R9 read");
    expect_now("R9 read clears lock", 5'b00110, 1'b1);
    rd_lsr = 1; step("R9 clean"); step("R9 clean");

    // R10 enables, R11 set beats clear
    ien = 5'b00000; ev_line_err = 1; step("R10 masked"); step("R10 masked");
    expect_now("R10 disabled line hidden", 5'b00001, 1'b0);
    ien = 5'b00100; step("R10 enable"); step("R10 enable");
    expect_now("R10 kept flag shows", 5'b00110, 1'b1);
    ien = 5'b11111;
    ev_line_err = 1; rd_lsr = 1; step("R11 both"); step("R11 both");
    expect_now("R11 set wins", 5'b00110, 1'b1);
    rd_lsr = 1; step("R11 clean"); step("R11 clean");

    // R12 random mix against the model
    void'($urandom(32'h1a2b3c4d));
    for (int i = 0; i < 4000; i++) begin
      ev_line_err = ($urandom_range(0, 99) < 4);
      ev_rx_data  = ($urandom_range(0, 99) < 6);
      ev_timeout  = ($urandom_range(0, 99) < 5);
      ev_ab_lock  = ($urandom_range(0, 99) < 3);
      rd_lsr      = ($urandom_range(0, 99) < 8);
      rd_rbr      = ($urandom_range(0, 99) < 8);
      rd_iir      = ($urandom_range(0, 99) < 12);
      rd_msr      = ($urandom_range(0, 99) < 8);
      wr_thr      = ($urandom_range(0, 99) < 8);
      fcr_rx_rst  = ($urandom_range(0, 99) < 3);
      if ($urandom_range(0, 99) < 10) rx_below_trig = ~rx_below_trig;
      if ($urandom_range(0, 99) < 10) thr_empty = ~thr_empty;
      if ($urandom_range(0, 99) < 15) tx_count = CW'($urandom_range(0, TXD));
      if ($urandom_range(0, 99) < 5)  modem_in[$urandom_range(0, 3)] ^= 1'b1;
      if ($urandom_range(0, 99) < 2)  fifo_en = ~fifo_en;
      if ($urandom_range(0, 99) < 3)  ien = 5'($urandom_range(0, 31));
      step("R12 random");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule